// File: doc/BRIEF.md
# Word-Wide LFSR with Field-Multiplied Feedback

This block is a sixteen-stage shift register in which every stage holds one 32-bit word. On each step every stage takes the word held by the stage above it, and the top stage receives a freshly computed feedback word. The feedback is not a simple XOR of taps. It is built from several terms:

- the bottom stage moved up by one byte;
- stage 11 moved down by one byte;
- stage 2 unchanged;
- two 8-to-32-bit mappings over GF(2^8). One expands the top byte of stage 0 by multiplication with a constant field element alpha. The other expands the bottom byte of stage 11 by division by alpha.

The register has two modes. In initialisation mode an external 32-bit word, normally produced by a nonlinear state machine next to this block, is also XORed into the feedback. In keystream mode that input is ignored.

A controller loads all sixteen stages in one cycle through a flat parallel load port. It then pulses the step enable once per word. The block exposes stages 0, 2, 5 and 15, which are the words a surrounding stream-cipher datapath consumes. The two field mappings are held in 256-entry tables. Constant functions fill these tables at elaboration, so one feedback word is ready within a single cycle.

Top module: `gfword_lfsr`

## Requirements
- R1: An active-low asynchronous reset clears all sixteen stages to zero, so every exposed stage reads 0 after reset.
- R2: When `load_en` is high at a clock edge, stage i takes `load_state[32*i+31 : 32*i]` for every i in 0..15. The exposed outputs then show stages 0, 2, 5 and 15 from the next cycle onwards.
- R3: When `load_en` and `step_en` are both high, the load wins and no shift takes place.
- R4: When neither `load_en` nor `step_en` is high, every stage keeps its value.
- R5: On a step without load, stage i takes the old value of stage i+1 for i = 0..14.
- R6: In keystream mode (`init_mode` = 0), a step writes this word v into stage 15: v = (s0 << 8, low byte zero) XOR MA(s0[31:24]) XOR s2 XOR (s11 >> 8, high byte zero) XOR DA(s11[7:0]). The value of `ext_word` has no effect in this mode.
- R7: In initialisation mode (`init_mode` = 1), the word written into stage 15 is the R6 word XOR `ext_word`.
- R8: MA(c) is the concatenation, most significant byte first, of P(c,23), P(c,245), P(c,48) and P(c,239). Here P(c,0) = c and P(c,k) = X(P(c,k-1)), where X(b) shifts b left by one bit and XORs 0xA9 into the result when bit 7 of b was 1.
- R9: DA(c) is the concatenation, most significant byte first, of P(c,16), P(c,39), P(c,6) and P(c,64), with P defined as in R8.
- R10: The all-zero state stepped in keystream mode stays all-zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Parallel load of all stages; has priority over step |
| load_state | input | 512 | Load word for stage i in bits [32*i+31:32*i] |
| step_en | input | 1 | Shift one stage and insert the feedback word |
| init_mode | input | 1 | 1 = initialisation mode (ext_word mixed in), 0 = keystream mode |
| ext_word | input | 32 | External word XORed into feedback in initialisation mode |
| s0_o | output | 32 | Stage 0 |
| s2_o | output | 32 | Stage 2 |
| s5_o | output | 32 | Stage 5 |
| s15_o | output | 32 | Stage 15 |

## Verification
The properties assume the control inputs are known, two-valued levels at every clock edge once reset is released. They also assume that `load_state` and `ext_word` are stable around the edge at which they are used. The stimulus meets this by changing every input only on the falling clock edge and by returning `load_en` and `step_en` to zero between operations. The zero-state properties assume that the mode input matches the intent of the step. The bench therefore drives `init_mode` explicitly for every step, including the steps it takes from an all-zero state.

// File: rtl/gfword_lfsr_pkg.sv
package gfword_lfsr_pkg;

    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BYTE_W-1:0] byte_t;

    // Exponents of the per-byte multiplier chains, most significant byte first.
    localparam int MA_E0 = 23;
    localparam int MA_E1 = 245;
    localparam int MA_E2 = 48;
    localparam int MA_E3 = 239;
    localparam int DA_E0 = 16;
    localparam int DA_E1 = 39;
    localparam int DA_E2 = 6;
    localparam int DA_E3 = 64;

    function automatic byte_t gf_dbl(byte_t b, byte_t poly);
        byte_t sh;
        sh = {b[BYTE_W-2:0], 1'b0};
        return b[BYTE_W-1] ? (sh ^ poly) : sh;
    endfunction

    function automatic byte_t gf_dbl_n(byte_t b, int n, byte_t poly);
        byte_t acc;
        acc = b;
        for (int k = 0; k < n; k++) begin
            acc = gf_dbl(acc, poly);
        end
        return acc;
    endfunction

    function automatic word_t alpha_mul_word(byte_t c, byte_t poly);
        return {gf_dbl_n(c, MA_E0, poly), gf_dbl_n(c, MA_E1, poly),
                gf_dbl_n(c, MA_E2, poly), gf_dbl_n(c, MA_E3, poly)};
    endfunction

    function automatic word_t alpha_div_word(byte_t c, byte_t poly);
        return {gf_dbl_n(c, DA_E0, poly), gf_dbl_n(c, DA_E1, poly),
                gf_dbl_n(c, DA_E2, poly), gf_dbl_n(c, DA_E3, poly)};
    endfunction

endpackage

// File: rtl/gfw_alpha_rom.sv
module gfw_alpha_rom
    import gfword_lfsr_pkg::*;
#(
    parameter bit    DIVIDE = 1'b0,
    parameter byte_t POLY   = 8'hA9
) (
    input  byte_t idx,
    output word_t word
);
    localparam int DEPTH = 1 << BYTE_W;

    word_t table_w [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        if (DIVIDE) begin : g_div
            assign table_w[g] = alpha_div_word(byte_t'(g), POLY);
        end else begin : g_mul
            assign table_w[g] = alpha_mul_word(byte_t'(g), POLY);
        end
    end

    assign word = table_w[idx];

endmodule

// File: rtl/gfw_feedback.sv
module gfw_feedback
    import gfword_lfsr_pkg::*;
#(
    parameter byte_t POLY = 8'hA9
) (
    input  word_t low_stage,
    input  word_t mid_stage,
    input  word_t high_stage,
    input  word_t ext_word,
    input  logic  inject,
    output word_t fb_word
);
    word_t mul_term;
    word_t div_term;
    word_t up_shift;
    word_t down_shift;
    word_t ext_term;

    gfw_alpha_rom #(.DIVIDE(1'b0), .POLY(POLY)) u_mul_rom (
        .idx  (low_stage[WORD_W-1 -: BYTE_W]),
        .word (mul_term)
    );

    gfw_alpha_rom #(.DIVIDE(1'b1), .POLY(POLY)) u_div_rom (
        .idx  (high_stage[BYTE_W-1:0]),
        .word (div_term)
    );

    always_comb begin
        up_shift   = {low_stage[WORD_W-BYTE_W-1:0], {BYTE_W{1'b0}}};
        down_shift = {{BYTE_W{1'b0}}, high_stage[WORD_W-1:BYTE_W]};
        ext_term   = inject ? ext_word : '0;
        fb_word    = up_shift ^ mul_term ^ mid_stage ^ down_shift ^ div_term ^ ext_term;
    end

endmodule

// File: rtl/gfword_lfsr.sv
module gfword_lfsr
    import gfword_lfsr_pkg::*;
#(
    parameter int    NSTAGES = 16,
    parameter byte_t POLY    = 8'hA9
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load_en,
    input  logic [NSTAGES*WORD_W-1:0]   load_state,
    input  logic                        step_en,
    input  logic                        init_mode,
    input  logic [WORD_W-1:0]           ext_word,
    output logic [WORD_W-1:0]           s0_o,
    output logic [WORD_W-1:0]           s2_o,
    output logic [WORD_W-1:0]           s5_o,
    output logic [WORD_W-1:0]           s15_o
);
    localparam int TAP_MID = 2;
    localparam int TAP_HI  = 11;
    localparam int TAP_OUT = 5;
    localparam int TOP     = NSTAGES - 1;

    typedef struct packed {
        logic [NSTAGES-1:0][WORD_W-1:0] stage;
    } state_t;

    state_t state_d;
    state_t state_q;
    word_t  fb_word;

    gfw_feedback #(.POLY(POLY)) u_fb (
        .low_stage  (state_q.stage[0]),
        .mid_stage  (state_q.stage[TAP_MID]),
        .high_stage (state_q.stage[TAP_HI]),
        .ext_word   (ext_word),
        .inject     (init_mode),
        .fb_word    (fb_word)
    );

    always_comb begin
        state_d = state_q;
        if (load_en) begin
            state_d.stage = load_state;
        end else if (step_en) begin
            for (int i = 0; i < TOP; i++) begin
                state_d.stage[i] = state_q.stage[i+1];
            end
            state_d.stage[TOP] = fb_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign s0_o  = state_q.stage[0];
    assign s2_o  = state_q.stage[TAP_MID];
    assign s5_o  = state_q.stage[TAP_OUT];
    assign s15_o = state_q.stage[TOP];

endmodule

// File: rtl/gfword_lfsr_chk.sv
module gfword_lfsr_chk
    import gfword_lfsr_pkg::*;
#(
    parameter int NSTAGES = 16
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          load_en,
    input logic                          step_en,
    input logic                          init_mode,
    input logic [WORD_W-1:0]             ext_word,
    input logic [NSTAGES*WORD_W-1:0]     load_state,
    input logic [NSTAGES-1:0][WORD_W-1:0] stage_q,
    input logic [WORD_W-1:0]             s0_o,
    input logic [WORD_W-1:0]             s15_o
);
    localparam int TOP = NSTAGES - 1;

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (s0_o == '0 && s15_o == '0)); // R1

    AST_LOAD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> s0_o == $past(load_state[WORD_W-1:0])); // R2

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && step_en) |=> s15_o == $past(load_state[NSTAGES*WORD_W-1 -: WORD_W])); // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !step_en) |=> $stable(stage_q)); // R4

    AST_SHIFT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load_en) |=> stage_q[TOP-1:0] == $past(stage_q[TOP:1])); // R5

    AST_ZERO_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load_en && !init_mode && stage_q == '0) |=> s15_o == '0); // R10

    AST_INIT_INJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load_en && init_mode && stage_q == '0) |=> s15_o == $past(ext_word)); // R7

endmodule

bind gfword_lfsr gfword_lfsr_chk #(.NSTAGES(NSTAGES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_en    (load_en),
    .step_en    (step_en),
    .init_mode  (init_mode),
    .ext_word   (ext_word),
    .load_state (load_state),
    .stage_q    (state_q.stage),
    .s0_o       (s0_o),
    .s15_o      (s15_o)
);

// File: tb/gfword_lfsr_bench.sv
`timescale 1ns/1ps
module gfword_lfsr_bench;
    localparam int N = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              load_en = 1'b0;
    logic [N*32-1:0]   load_state = '0;
    logic              step_en = 1'b0;
    logic              init_mode = 1'b0;
    logic [31:0]       ext_word = '0;
    logic [31:0]       s0_o, s2_o, s5_o, s15_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m [N];

    always #2.5 clk = ~clk;

    gfword_lfsr u_gfword_lfsr (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_state(load_state),
        .step_en(step_en), .init_mode(init_mode), .ext_word(ext_word),
        .s0_o(s0_o), .s2_o(s2_o), .s5_o(s5_o), .s15_o(s15_o)
    );

    // Behavioural reference: iterated doubling in GF(2^8) with 0xA9.
    function automatic logic [7:0] ref_pow(logic [7:0] v, int n);
        logic [7:0] a;
        a = v;
        for (int k = 0; k < n; k++) begin
            if (a[7]) a = (a << 1) ^ 8'hA9;
            else      a = a << 1;
        end
        return a;
    endfunction

    function automatic logic [31:0] ref_ma(logic [7:0] c);
        return {ref_pow(c, 23), ref_pow(c, 245), ref_pow(c, 48), ref_pow(c, 239)};
    endfunction

    function automatic logic [31:0] ref_da(logic [7:0] c);
        return {ref_pow(c, 16), ref_pow(c, 39), ref_pow(c, 6), ref_pow(c, 64)};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic check_outs(input string req);
        check(s0_o  == m[0],  req, s0_o,  m[0]);
        check(s2_o  == m[2],  req, s2_o,  m[2]);
        check(s5_o  == m[5],  req, s5_o,  m[5]);
        check(s15_o == m[15], req, s15_o, m[15]);
    endtask

    task automatic do_load(input logic [31:0] w [N]);
        @(negedge clk);
        for (int i = 0; i < N; i++) load_state[32*i +: 32] = w[i];
        load_en = 1'b1;
        @(posedge clk);
        for (int i = 0; i < N; i++) m[i] = w[i];
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic do_step(input bit mode, input logic [31:0] ext);
        logic [31:0] v;
        @(negedge clk);
        step_en = 1'b1;
        init_mode = mode;
        ext_word = ext;
        @(posedge clk);
        v = {m[0][23:0], 8'h00} ^ ref_ma(m[0][31:24]) ^ m[2] ^
            {8'h00, m[11][31:8]} ^ ref_da(m[11][7:0]) ^ (mode ? ext : 32'h0);
        for (int i = 0; i < N-1; i++) m[i] = m[i+1];
        m[N-1] = v;
        @(negedge clk);
        step_en = 1'b0;
    endtask

    task automatic rand_state(output logic [31:0] w [N]);
        for (int i = 0; i < N; i++) w[i] = $urandom;
    endtask

    task automatic t_reset;
        for (int i = 0; i < N; i++) m[i] = '0;
        check_outs("R1");
    endtask

    task automatic t_load;
        logic [31:0] w [N];
        for (int r = 0; r < 3; r++) begin
            rand_state(w);
            do_load(w);
            check_outs("R2");
        end
    endtask

    task automatic t_hold;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            ext_word = $urandom;
            init_mode = c[0];
            check_outs("R4");
        end
    endtask

    task automatic t_prio;
        logic [31:0] w [N];
        rand_state(w);
        @(negedge clk);
        for (int i = 0; i < N; i++) load_state[32*i +: 32] = w[i];
        load_en = 1'b1;
        step_en = 1'b1;
        init_mode = 1'b1;
        ext_word = $urandom;
        @(posedge clk);
        for (int i = 0; i < N; i++) m[i] = w[i];
        @(negedge clk);
        load_en = 1'b0;
        step_en = 1'b0;
        check_outs("R3");
    endtask

    task automatic t_keystream;
        logic [31:0] w [N];
        logic [31:0] prev1;
        rand_state(w);
        do_load(w);
        for (int s = 0; s < 40; s++) begin
            prev1 = m[1];
            do_step(1'b0, $urandom);
            check(s0_o == prev1, "R5", s0_o, prev1);
            check_outs("R6");
        end
    endtask

    task automatic t_init;
        logic [31:0] w [N];
        rand_state(w);
        do_load(w);
        for (int s = 0; s < 40; s++) begin
            do_step(1'b1, $urandom);
            check_outs("R7");
        end
    endtask

    task automatic t_mul_corner;
        logic [31:0] w [N];
        logic [7:0] vals [4] = '{8'h01, 8'h80, 8'hFF, 8'h53};
        for (int k = 0; k < 4; k++) begin
            for (int i = 0; i < N; i++) w[i] = '0;
            w[0] = {vals[k], 24'h0};
            do_load(w);
            do_step(1'b0, 32'hFFFF_FFFF);
            check(s15_o == ref_ma(vals[k]), "R8", s15_o, ref_ma(vals[k]));
        end
    endtask

    task automatic t_div_corner;
        logic [31:0] w [N];
        logic [7:0] vals [4] = '{8'h01, 8'h80, 8'hFF, 8'hC4};
        for (int k = 0; k < 4; k++) begin
            for (int i = 0; i < N; i++) w[i] = '0;
            w[11] = {24'h0, vals[k]};
            do_load(w);
            do_step(1'b0, 32'h1234_5678);
            check(s15_o == ref_da(vals[k]), "R9", s15_o, ref_da(vals[k]));
        end
    endtask

    task automatic t_zero;
        logic [31:0] w [N];
        for (int i = 0; i < N; i++) w[i] = '0;
        do_load(w);
        for (int s = 0; s < 5; s++) begin
            do_step(1'b0, $urandom);
            check(s15_o == 32'h0 && s0_o == 32'h0, "R10", s15_o, 32'h0);
        end
        do_step(1'b1, 32'hA5A5_0F0F);
        check(s15_o == 32'hA5A5_0F0F, "R7", s15_o, 32'hA5A5_0F0F);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=%08h expected=%08h", 32'h0, 32'h1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #12 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load();
        t_hold();
        t_prio();
        t_keystream();
        t_init();
        t_mul_corner();
        t_div_corner();
        t_zero();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule